// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block keeps four 16-bit segment base registers and turns a 16-bit offset into a 20-bit physical address. It computes the address as the selected segment shifted left by four bits plus the offset, and it discards any carry out of the top bit, so the address space of 1 MB wraps around. Each segment value therefore marks the start of a 64 KB window, and every window starts on a 16-byte boundary.

The caller gives the kind of access, and the block picks the segment from that:

- Instruction fetches use the code segment.
- Stack references through the stack or base pointer use the stack segment.
- General data references use the data segment.
- String destinations use the extra segment.

For the two data-style access kinds, an override select can name any segment instead of the default. The override is ignored for fetches and for string destinations.

A write port loads one segment register per clock. The path from the registers to the address is combinational, so a newly written value is used from the cycle after the write.

Top module: `seg_addr_gen`

## Requirements
- R1: `phys_addr_o` equals (selected segment × 16 + `offset_i`) modulo 2^20. It is combinational from the current register contents and the inputs.
- R2: A carry out of address bit 19 is dropped. For example, segment 16'hFFFF with offset 16'hFFFF gives 20'h0FFEF.
- R3: For `acc_type_i`=0 (instruction fetch), `seg_used_o`=1 (code), whatever the override inputs are.
- R4: For `acc_type_i`=1 (stack or base pointer reference) with `ovr_valid_i`=0, `seg_used_o`=2 (stack).
- R5: For `acc_type_i`=2 (general data reference) with `ovr_valid_i`=0, `seg_used_o`=3 (data).
- R6: For `acc_type_i`=3 (string destination), `seg_used_o`=0 (extra), whatever the override inputs are.
- R7: For `acc_type_i` 1 or 2 with `ovr_valid_i`=1, `seg_used_o` equals `ovr_sel_i`, and that segment forms the address.
- R8: A write with `wr_en_i`=1 loads `wr_data_i` into the register coded by `wr_sel_i` at the rising clock edge. The address reflects the new value from the next cycle on, not in the cycle of the write.
- R9: After reset all four segment registers read as zero, so `phys_addr_o` equals the offset.
- R10: A write changes only the addressed register; the other three keep their values.

Segment codes are 0 = extra, 1 = code, 2 = stack, 3 = data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Segment register write enable |
| wr_sel_i | input | 2 | Register to write (segment code) |
| wr_data_i | input | 16 | Value to write |
| acc_type_i | input | 2 | Access kind: 0 fetch, 1 stack, 2 data, 3 string destination |
| ovr_valid_i | input | 1 | Override select is valid |
| ovr_sel_i | input | 2 | Override segment code |
| offset_i | input | 16 | Offset within the segment |
| phys_addr_o | output | 20 | Physical address |
| seg_used_o | output | 2 | Segment code that was used |

## Verification
Directed cases come first:

- Reading straight out of reset shows that the offset passes through unchanged while every base is zero.
- An all-ones segment with an all-ones offset separates a correct wrap from a widened sum.
- Writing a register in the same cycle that it is read separates a next-cycle update from a write-through.
- Overrides applied to each access kind show whether they are honoured only for stack and data references.

Random traffic then mixes writes to random registers with reads through all access kinds and override settings. This exposes a write that leaks into a register other than the one addressed, or a wrong default mapping.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int NUM_SEG = 4;
  localparam int SEL_W   = $clog2(NUM_SEG);

  typedef enum logic [1:0] {
    ACC_FETCH  = 2'd0,
    ACC_STACK  = 2'd1,
    ACC_DATA   = 2'd2,
    ACC_STRDST = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    SEG_EXTRA = 2'd0,
    SEG_CODE  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_DATA  = 2'd3
  } seg_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [SEL_W-1:0]              wr_sel_i,
  input  logic [SEG_W-1:0]              wr_data_i,
  output logic [NUM_SEG-1:0][SEG_W-1:0] seg_q_o
);
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic hit;
    assign hit = wr_en_i && (wr_sel_i == SEL_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  seg_q_o[g] <= '0;
      else if (hit) seg_q_o[g] <= wr_data_i;
    end
  end
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
(
  input  acc_e             acc_type_i,
  input  logic             ovr_valid_i,
  input  logic [SEL_W-1:0] ovr_sel_i,
  output logic [SEL_W-1:0] sel_o
);
  seg_e dflt;

  always_comb begin
    unique case (acc_type_i)
      ACC_FETCH: dflt = SEG_CODE;
      ACC_STACK: dflt = SEG_STACK;
      ACC_DATA:  dflt = SEG_DATA;
      default:   dflt = SEG_EXTRA;
    endcase
  end

  // override only for stack and data references
  always_comb begin
    if (ovr_valid_i && (acc_type_i == ACC_STACK || acc_type_i == ACC_DATA))
      sel_o = ovr_sel_i;
    else
      sel_o = dflt;
  end
endmodule

// File: rtl/addr_adder.sv
module addr_adder #(
  parameter int SEG_W   = 16,
  parameter int OFF_W   = 16,
  parameter int SHIFT_W = 4,
  localparam int ADDR_W = SEG_W + SHIFT_W
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] off_ext;

  assign base    = {seg_i, {SHIFT_W{1'b0}}};
  assign off_ext = ADDR_W'(off_i);
  // sum kept at ADDR_W bits: carry out is dropped
  assign addr_o  = base + off_ext;
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W   = 16,
  parameter int OFF_W   = 16,
  parameter int SHIFT_W = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [1:0]                 wr_sel_i,
  input  logic [SEG_W-1:0]           wr_data_i,
  input  logic [1:0]                 acc_type_i,
  input  logic                       ovr_valid_i,
  input  logic [1:0]                 ovr_sel_i,
  input  logic [OFF_W-1:0]           offset_i,
  output logic [SEG_W+SHIFT_W-1:0]   phys_addr_o,
  output logic [1:0]                 seg_used_o
);
  logic [NUM_SEG-1:0][SEG_W-1:0] seg_q;
  logic [SEL_W-1:0]              sel;

  seg_regfile #(.SEG_W(SEG_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .seg_q_o   (seg_q)
  );

  seg_select u_sel (
    .acc_type_i  (acc_e'(acc_type_i)),
    .ovr_valid_i (ovr_valid_i),
    .ovr_sel_i   (ovr_sel_i),
    .sel_o       (sel)
  );

  addr_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT_W(SHIFT_W)) u_add (
    .seg_i  (seg_q[sel]),
    .off_i  (offset_i),
    .addr_o (phys_addr_o)
  );

  assign seg_used_o = sel;
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int SEG_W   = 16,
  parameter int OFF_W   = 16,
  parameter int SHIFT_W = 4,
  localparam int ADDR_W = SEG_W + SHIFT_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        wr_sel_i,
  input logic [SEG_W-1:0]  wr_data_i,
  input logic [1:0]        acc_type_i,
  input logic              ovr_valid_i,
  input logic [1:0]        ovr_sel_i,
  input logic [OFF_W-1:0]  offset_i,
  input logic [ADDR_W-1:0] phys_addr_o,
  input logic [1:0]        seg_used_o
);
  logic [3:0][SEG_W-1:0] shadow;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shadow <= '0;
    else if (wr_en_i) shadow[wr_sel_i] <= wr_data_i;
  end

  // R1
  addr_calc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_addr_o == ADDR_W'({shadow[seg_used_o], {SHIFT_W{1'b0}}} + ADDR_W'(offset_i)));

  // R3
  fetch_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_type_i == 2'd0 |-> seg_used_o == 2'd1);

  // R4
  stack_dflt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_type_i == 2'd1 && !ovr_valid_i) |-> seg_used_o == 2'd2);

  // R5
  data_dflt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_type_i == 2'd2 && !ovr_valid_i) |-> seg_used_o == 2'd3);

  // R6
  strdst_extra_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_type_i == 2'd3 |-> seg_used_o == 2'd0);

  // R7
  override_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_valid_i && (acc_type_i == 2'd1 || acc_type_i == 2'd2)) |-> seg_used_o == ovr_sel_i);

  // R8
  write_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (seg_used_o != $past(wr_sel_i) ||
                 phys_addr_o == ADDR_W'({$past(wr_data_i), {SHIFT_W{1'b0}}} + ADDR_W'(offset_i))));
endmodule

bind seg_addr_gen seg_addr_gen_chk #(
  .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT_W(SHIFT_W)
) u_chk (.*);

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [1:0]  acc_type_i = '0;
  logic        ovr_valid_i = 1'b0;
  logic [1:0]  ovr_sel_i = '0;
  logic [15:0] offset_i = '0;
  logic [19:0] phys_addr_o;
  logic [1:0]  seg_used_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [15:0] model [4];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  seg_addr_gen u_seg_addr_gen (.*);

  function automatic logic [1:0] exp_seg(logic [1:0] acc, logic ov, logic [1:0] os);
    case (acc)
      2'd0:    return 2'd1;
      2'd1:    return ov ? os : 2'd2;
      2'd2:    return ov ? os : 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [19:0] exp_addr(logic [15:0] seg, logic [15:0] off);
    logic [20:0] s;
    s = {1'b0, seg, 4'h0} + {5'h0, off};
    return s[19:0];
  endfunction

  function automatic string seg_tag(logic [1:0] acc, logic ov);
    if (acc == 2'd0) return "R3";
    if (acc == 2'd3) return "R6";
    if (ov) return "R7";
    return (acc == 2'd1) ? "R4" : "R5";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic we, logic [1:0] ws, logic [15:0] wd, logic [1:0] acc,
                      logic ov, logic [1:0] os, logic [15:0] off, string atag);
    logic [1:0] es;
    @(negedge clk_i);
    wr_en_i = we; wr_sel_i = ws; wr_data_i = wd;
    acc_type_i = acc; ovr_valid_i = ov; ovr_sel_i = os; offset_i = off;
    #1;
    es = exp_seg(acc, ov, os);
    check(seg_tag(acc, ov), 32'(seg_used_o), 32'(es));
    check(atag, 32'(phys_addr_o), 32'(exp_addr(model[es], off)));
    @(posedge clk_i);
    if (we) model[ws] = wd;
    #1;
    wr_en_i = 1'b0;
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R9 reset state: address equals offset for every access kind
    for (int a = 0; a < 4; a++) step(1'b0, 2'd0, 16'h0, 2'(a), 1'b0, 2'd0, 16'h1234, "R9");

    // R8 write code segment; same-cycle read still sees old value
    step(1'b1, 2'd1, 16'hFFFF, 2'd0, 1'b0, 2'd0, 16'h0010, "R8");
    // R2 R8 new value visible, and wrap beyond bit 19
    step(1'b0, 2'd0, 16'h0, 2'd0, 1'b0, 2'd0, 16'hFFFF, "R2 R8");

    // load other segments
    step(1'b1, 2'd3, 16'h2000, 2'd2, 1'b0, 2'd0, 16'h0001, "R8");
    step(1'b1, 2'd2, 16'h3000, 2'd1, 1'b0, 2'd0, 16'h0002, "R8");
    step(1'b1, 2'd0, 16'h4000, 2'd3, 1'b0, 2'd0, 16'h0003, "R8");

    // R3 R6 override ignored; R7 override honoured; R10 others intact
    step(1'b0, 2'd0, 16'h0, 2'd0, 1'b1, 2'd3, 16'h0100, "R3 R10");
    step(1'b0, 2'd0, 16'h0, 2'd3, 1'b1, 2'd2, 16'h0200, "R6 R10");
    step(1'b0, 2'd0, 16'h0, 2'd1, 1'b1, 2'd3, 16'h0300, "R7 R10");
    step(1'b0, 2'd0, 16'h0, 2'd2, 1'b1, 2'd0, 16'h0400, "R7 R10");
    step(1'b0, 2'd0, 16'h0, 2'd2, 1'b0, 2'd0, 16'hFFFF, "R5 R1");
    step(1'b0, 2'd0, 16'h0, 2'd1, 1'b0, 2'd0, 16'h8000, "R4 R1");

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 4) == 0, 2'($urandom), 16'($urandom), 2'($urandom),
           1'($urandom), 2'($urandom), 16'($urandom), "R1 R10");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule